// File: doc/BRIEF.md
# Converter Bring-Up Sequencer

This controller takes an external high-speed data converter from power-up to a fully programmed state. A start pulse launches the sequence. The controller first waits until the supply-good input has been steady for a programmed time. It then turns on the converter's SYSREF output and applies one active-high reset pulse. While the reset is high, and for a short guard time after it falls, the serial register interface is held off.

After the guard time the controller plays four register tables out through a write-request port. The tables go out in this order:

1. analog trim values,
2. an interleave setup chosen by the Nyquist zone,
3. a nonlinearity setup for the same zone,
4. the decimator and serial-link setup.

Between the interleave table and the nonlinearity table the controller pauses for a long estimation time, so the converter can measure its interleaving errors.

Each table entry is a 16-bit register address with an 8-bit value. An entry stays on the port until the serial shifter outside the block returns a write-done strobe. Every delay is given in nanoseconds and turned into clock cycles from the clock-frequency parameter, rounding up. A new start at any time aborts the run and begins again from the supply wait. The trim table is written on every run.

Top module: `adc_boot_seq`

## Requirements
- R1: While reset is asserted, and while idle after reset, `sysref_en`, `adc_reset`, `spi_hold`, `wr_req`, `busy` and `done` are all low.
- R2: On the cycle after `start` is sampled high, `busy` and `spi_hold` are high, and `sysref_en` and `wr_req` are low.
- R3: `sysref_en` rises on the PWR_CYC-th consecutive clock edge at which `pwr_good` is sampled high during the supply wait. A low sample restarts the count. Every delay X_CYC is ceil(X_NS * CLK_HZ / 1e9), with a minimum of 1.
- R4: `adc_reset` rises one cycle after `sysref_en` rises and stays high for exactly RST_CYC cycles.
- R5: `spi_hold` falls exactly SEN_CYC cycles after `adc_reset` falls. The first write request appears in that same cycle.
- R6: Writes are issued in this order: trim (N_TRIM entries, tag 1), interleave (N_IL, tag 2), nonlinearity (N_NL, tag 3), link (N_LINK, tag 4). Entry k has address {tag[3:0], zf[1:0], 2'b00, k[7:0]} and data {tag[3:0], k[3:0]} XOR {2'b00, zf, 4'b0000}. Here zf is the latched zone for tags 2 and 3, and 0 for tags 1 and 4.
- R7: An entry holds steady on the port until `wr_done` is sampled high while `wr_req` is high. The next entry is presented in the following cycle. `wr_done` has no effect while `wr_req` is low.
- R8: Between the last interleave write being accepted and the first nonlinearity request, `wr_req` stays low for exactly EST_CYC cycles while `busy` is high.
- R9: `zone` is latched when `start` is accepted. Later changes on the input do not alter the tables written.
- R10: `done` pulses high for one cycle, on the cycle after the last link entry is accepted. `busy` falls in that same cycle, and `sysref_en` stays high afterwards.
- R11: A `start` during the table phase aborts the run. On the next cycle `sysref_en`, `adc_reset` and `wr_req` are low and `spi_hold` is high. The full sequence then repeats with the newly latched zone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run (or rerun) the whole sequence |
| pwr_good | input | 1 | Converter supplies are up |
| zone | input | 2 | Nyquist zone selecting the interleave and nonlinearity tables |
| wr_done | input | 1 | Serial shifter finished the presented write |
| sysref_en | output | 1 | Enables the SYSREF output to the converter |
| adc_reset | output | 1 | Active-high hardware reset pulse to the converter |
| spi_hold | output | 1 | Holds the serial register interface off |
| wr_req | output | 1 | A register write is being presented |
| wr_addr | output | 16 | Register address of the presented write |
| wr_data | output | 8 | Register value of the presented write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show up as timing errors at the ports within a single phase. A wrong load value or a wrong state transition in the shared countdown shifts an edge of `sysref_en`, `adc_reset` or `spi_hold`, or changes the length of the quiet gap before the nonlinearity table. These are measured to the exact cycle. A corrupted table index, table tag or latched zone shows up on the first write whose address or data differ from the value computed from R6. An early or late jump to idle shows up as a `done` pulse while `busy` is still high, or as a write count that is off.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_SREF, S_RSTHI, S_SENW,
    S_TRIM, S_IL, S_EST, S_NL, S_LINK
  } boot_st_t;

  localparam logic [3:0] TAG_TRIM = 4'd1;
  localparam logic [3:0] TAG_IL   = 4'd2;
  localparam logic [3:0] TAG_NL   = 4'd3;
  localparam logic [3:0] TAG_LINK = 4'd4;

  // Cycles covering at least ns nanoseconds at hz, never below one.
  function automatic longint ns_to_cycles(input longint hz, input longint ns);
    longint c;
    c = (hz * ns + 64'sd999_999_999) / 64'sd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_boot_rstsync.sv
module adc_boot_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/adc_boot_timer.sv
module adc_boot_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_boot_rom.sv
module adc_boot_rom #(
  parameter int IDX_W = 3
) (
  input  logic [3:0]       tag,
  input  logic [1:0]       zone,
  input  logic             zoned,
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      addr,
  output logic [7:0]       data
);
  logic [7:0] idx8;
  logic [1:0] zf;

  generate
    if (IDX_W >= 8) begin : g_wide
      assign idx8 = idx[7:0];
    end else begin : g_narrow
      assign idx8 = {{(8-IDX_W){1'b0}}, idx};
    end
  endgenerate

  assign zf   = zoned ? zone : 2'b00;
  assign addr = {tag, zf, 2'b00, idx8};
  assign data = {tag, idx8[3:0]} ^ {2'b00, zf, 4'b0000};
endmodule

// File: rtl/adc_boot_seq.sv
module adc_boot_seq
  import adc_boot_pkg::*;
#(
  parameter longint CLK_HZ = 100_000_000,
  parameter longint PWR_NS = 1_000_000,
  parameter longint RST_NS = 1_000,
  parameter longint SEN_NS = 100,
  parameter longint EST_NS = 50_000_000,
  parameter int     N_TRIM = 6,
  parameter int     N_IL   = 4,
  parameter int     N_NL   = 5,
  parameter int     N_LINK = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pwr_good,
  input  logic [1:0]  zone,
  input  logic        wr_done,
  output logic        sysref_en,
  output logic        adc_reset,
  output logic        spi_hold,
  output logic        wr_req,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        busy,
  output logic        done
);
  localparam longint PWR_CYC = ns_to_cycles(CLK_HZ, PWR_NS);
  localparam longint RST_CYC = ns_to_cycles(CLK_HZ, RST_NS);
  localparam longint SEN_CYC = ns_to_cycles(CLK_HZ, SEN_NS);
  localparam longint EST_CYC = ns_to_cycles(CLK_HZ, EST_NS);
  localparam longint MAX_A   = (PWR_CYC > EST_CYC) ? PWR_CYC : EST_CYC;
  localparam longint MAX_B   = (RST_CYC > SEN_CYC) ? RST_CYC : SEN_CYC;
  localparam longint MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int     CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] SEN_LD = CNT_W'(SEN_CYC - 1);
  localparam logic [CNT_W-1:0] EST_LD = CNT_W'(EST_CYC - 1);
  localparam int LEN_A   = (N_TRIM > N_IL) ? N_TRIM : N_IL;
  localparam int LEN_B   = (N_NL > N_LINK) ? N_NL : N_LINK;
  localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int IDX_W   = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

  logic              rst_ni;
  boot_st_t          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d, tbl_last;
  logic [1:0]        zone_q, zone_d;
  logic              sref_q, sref_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept;
  logic [3:0]        tag;
  logic              zoned;
  logic              reset_q, hold_q, req_q, busy_q, done_q, done_d;

  adc_boot_rstsync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_ni)
  );

  adc_boot_timer #(.W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  assign accept = req_q & wr_done;

  // Per-table selection: tag, zone use and last index.
  always_comb begin
    tag      = TAG_TRIM;
    zoned    = 1'b0;
    tbl_last = IDX_W'(N_TRIM - 1);
    case (st_q)
      S_IL:   begin tag = TAG_IL;   zoned = 1'b1; tbl_last = IDX_W'(N_IL - 1);   end
      S_NL:   begin tag = TAG_NL;   zoned = 1'b1; tbl_last = IDX_W'(N_NL - 1);   end
      S_LINK: begin tag = TAG_LINK; zoned = 1'b0; tbl_last = IDX_W'(N_LINK - 1); end
      default: ;
    endcase
  end

  adc_boot_rom #(.IDX_W(IDX_W)) u_rom (
    .tag  (tag),
    .zone (zone_q),
    .zoned(zoned),
    .idx  (idx_q),
    .addr (wr_addr),
    .data (wr_data)
  );

  // Next-state logic.
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    zone_d   = zone_q;
    sref_d   = sref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done_d   = 1'b0;
    if (start) begin
      st_d     = S_PWR;
      idx_d    = '0;
      zone_d   = zone;
      sref_d   = 1'b0;
      tmr_load = 1'b1;
      tmr_val  = PWR_LD;
    end else begin
      case (st_q)
        S_PWR: begin
          if (!pwr_good) begin
            tmr_load = 1'b1;
            tmr_val  = PWR_LD;
          end else if (tmr_zero) begin
            st_d   = S_SREF;
            sref_d = 1'b1;
          end
        end
        S_SREF: begin
          st_d     = S_RSTHI;
          tmr_load = 1'b1;
          tmr_val  = RST_LD;
        end
        S_RSTHI: if (tmr_zero) begin
          st_d     = S_SENW;
          tmr_load = 1'b1;
          tmr_val  = SEN_LD;
        end
        S_SENW: if (tmr_zero) st_d = S_TRIM;
        S_EST:  if (tmr_zero) st_d = S_NL;
        S_TRIM, S_IL, S_NL, S_LINK: if (accept) begin
          if (idx_q == tbl_last) begin
            idx_d = '0;
            case (st_q)
              S_TRIM: st_d = S_IL;
              S_IL: begin
                st_d     = S_EST;
                tmr_load = 1'b1;
                tmr_val  = EST_LD;
              end
              S_NL:   st_d = S_LINK;
              default: begin
                st_d   = S_IDLE;
                done_d = 1'b1;
              end
            endcase
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      zone_q  <= '0;
      sref_q  <= 1'b0;
      reset_q <= 1'b0;
      hold_q  <= 1'b0;
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      zone_q  <= zone_d;
      sref_q  <= sref_d;
      reset_q <= (st_d == S_RSTHI);
      hold_q  <= (st_d inside {S_PWR, S_SREF, S_RSTHI, S_SENW});
      req_q   <= (st_d inside {S_TRIM, S_IL, S_NL, S_LINK});
      busy_q  <= (st_d != S_IDLE);
      done_q  <= done_d;
    end
  end

  assign sysref_en = sref_q;
  assign adc_reset = reset_q;
  assign spi_hold  = hold_q;
  assign wr_req    = req_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/adc_boot_seq_chk.sv
module adc_boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_done,
  input logic        sysref_en,
  input logic        adc_reset,
  input logic        spi_hold,
  input logic        wr_req,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        busy,
  input logic        done
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_req && !adc_reset && !spi_hold));

  a_r4_reset_after_sysref: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reset |-> sysref_en);

  a_r4_hold_over_reset: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reset |-> spi_hold);

  a_r5_hold_outlasts_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_reset) |-> spi_hold);

  a_r5_no_write_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (!spi_hold && !adc_reset && sysref_en && busy));

  a_r7_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done && !start) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind adc_boot_seq adc_boot_seq_chk u_chk (.*);

// File: tb/adc_boot_seq_bench.sv
module adc_boot_seq_bench;
  localparam longint PWR_C = 4000;   // 1 ms at 4 MHz
  localparam longint RST_C = 4;      // 1 us at 4 MHz
  localparam longint SEN_C = 1;      // 100 ns at 4 MHz, rounded up
  localparam longint EST_C = 20000;  // 5 ms at 4 MHz
  localparam int N_TRIM = 6, N_IL = 4, N_NL = 5, N_LINK = 3;
  localparam int N_ALL = N_TRIM + N_IL + N_NL + N_LINK;

  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pwr_good = 1'b0;
  logic [1:0] zone = 2'd0;
  logic resp_done = 1'b0, spur_done = 1'b0;
  logic wr_done;
  logic sysref_en, adc_reset, spi_hold, wr_req, busy, done;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  assign wr_done = resp_done | spur_done;

  adc_boot_seq #(.CLK_HZ(4_000_000), .EST_NS(5_000_000)) u_adc_boot_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_good(pwr_good), .zone(zone),
    .wr_done(wr_done), .sysref_en(sysref_en), .adc_reset(adc_reset),
    .spi_hold(spi_hold), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0, sb_fail = 0;
  longint cyc = 0, c0 = 0, c1 = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Scoreboard driver side: expected writes from the R6 encoding.
  wr_t exp_q[$];
  wr_t e_pop;
  task automatic push_tbl(input logic [3:0] tag, input logic [1:0] zf, input int n);
    for (int k = 0; k < n; k++) begin
      wr_t e;
      e.a = {tag, zf, 2'b00, 8'(k)};
      e.d = {tag, 4'(k)} ^ {2'b00, zf, 4'b0000};
      exp_q.push_back(e);
    end
  endtask
  task automatic push_all(input logic [1:0] z);
    push_tbl(4'd1, 2'd0, N_TRIM);
    push_tbl(4'd2, z,    N_IL);
    push_tbl(4'd3, z,    N_NL);
    push_tbl(4'd4, 2'd0, N_LINK);
  endtask

  // Responder and monitor: answers requests with latency 0..2, checks each.
  int acc_cnt = 0, lat_cnt = 0;
  bit hold_resp = 1'b0;
  always @(negedge clk) begin
    if (resp_done) resp_done <= 1'b0;
    else if (rst_n && wr_req && !hold_resp) begin
      if (lat_cnt >= acc_cnt % 3) begin
        lat_cnt = 0;
        resp_done <= 1'b1;
        acc_cnt++;
        if (exp_q.size() == 0) begin
          sb_fail++;
          chk(1'b0, "R6", "unexpected write", longint'(wr_addr), 0);
        end else begin
          e_pop = exp_q.pop_front();
          if (wr_addr != e_pop.a || wr_data != e_pop.d) sb_fail++;
          chk(wr_addr == e_pop.a, "R6", "write address", longint'(wr_addr), longint'(e_pop.a));
          chk(wr_data == e_pop.d, "R6", "write data", longint'(wr_data), longint'(e_pop.d));
        end
      end else lat_cnt++;
    end
  end

  // Edge timing monitor.
  longint t_sref, t_rr, t_rf, t_hf, t_req;
  int rst_cnt, gap, done_cnt, done_busy;
  task automatic clear_meas();
    t_sref = -1; t_rr = -1; t_rf = -1; t_hf = -1; t_req = -1;
    rst_cnt = 0; gap = 0; done_cnt = 0; done_busy = 0;
  endtask
  always @(negedge clk) if (rst_n) begin
    if (sysref_en && t_sref < 0) t_sref = cyc;
    if (adc_reset && t_rr < 0) t_rr = cyc;
    if (adc_reset) rst_cnt++;
    if (t_rr >= 0 && !adc_reset && t_rf < 0) t_rf = cyc;
    if (t_rf >= 0 && !spi_hold && t_hf < 0) t_hf = cyc;
    if (wr_req && t_req < 0) t_req = cyc;
    if (busy && !spi_hold && !wr_req) gap++;
    if (done) begin done_cnt++; if (busy) done_busy++; end
  end

  task automatic finish_run(input string tag_s);
    wait (done_cnt > 0);
    @(negedge clk);
    @(negedge clk);
    chk(gap == EST_C, "R8", {tag_s, " estimation gap"}, gap, EST_C);
    chk(exp_q.size() == 0, "R6", {tag_s, " writes left over"}, exp_q.size(), 0);
    chk(acc_cnt == N_ALL, "R7", {tag_s, " accepted writes"}, acc_cnt, N_ALL);
    chk(done_cnt == 1, "R10", {tag_s, " done pulses"}, done_cnt, 1);
    chk(done_busy == 0, "R10", {tag_s, " done while busy"}, done_busy, 0);
    chk(sysref_en == 1'b1, "R10", {tag_s, " sysref kept"}, sysref_en, 1);
    chk(busy == 1'b0, "R10", {tag_s, " busy after done"}, busy, 0);
  endtask

  initial begin
    clear_meas();
    repeat (3) @(negedge clk);
    chk({sysref_en, adc_reset, spi_hold, wr_req, busy, done} == 6'b0, "R1",
        "outputs in reset", longint'({sysref_en, adc_reset, spi_hold, wr_req, busy, done}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({sysref_en, adc_reset, spi_hold, wr_req, busy, done} == 6'b0, "R1",
        "outputs idle", longint'({sysref_en, adc_reset, spi_hold, wr_req, busy, done}), 0);

    // Run A: supply already good, zone 2; zone input changes afterwards (R9).
    pwr_good = 1'b1; zone = 2'd2; push_all(2'd2); acc_cnt = 0;
    start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0; clear_meas(); zone = 2'd1;
    chk(busy && spi_hold && !sysref_en && !wr_req, "R2", "state after start",
        longint'({busy, spi_hold, sysref_en, wr_req}), 4'b1100);
    wait (gap > 100);
    @(negedge clk); spur_done = 1'b1;   // R7: ignored with no request pending
    @(negedge clk); spur_done = 1'b0;
    finish_run("run A");
    chk(t_sref - c0 - 1 == PWR_C, "R3", "supply wait", t_sref - c0 - 1, PWR_C);
    chk(t_rr - t_sref == 1, "R4", "reset after sysref", t_rr - t_sref, 1);
    chk(t_rf - t_rr == RST_C, "R4", "reset width", t_rf - t_rr, RST_C);
    chk(rst_cnt == RST_C, "R4", "reset high samples", rst_cnt, RST_C);
    chk(t_hf - t_rf == SEN_C, "R5", "hold after reset", t_hf - t_rf, SEN_C);
    chk(t_req == t_hf, "R5", "first request cycle", t_req, t_hf);
    chk(sb_fail == 0, "R9", "tables use latched zone", sb_fail, 0);

    // Run B: supply glitches during the wait, then restart mid-table.
    zone = 2'd1; pwr_good = 1'b0; push_all(2'd1); acc_cnt = 0;
    start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0; clear_meas();
    chk(busy && spi_hold && !sysref_en && !wr_req, "R2", "state after second start",
        longint'({busy, spi_hold, sysref_en, wr_req}), 4'b1100);
    repeat (50) @(negedge clk); pwr_good = 1'b1;
    repeat (100) @(negedge clk); pwr_good = 1'b0;
    repeat (10) @(negedge clk); pwr_good = 1'b1; c1 = cyc;
    chk(t_sref == -1, "R3", "no sysref before count", t_sref, -1);
    wait (t_sref >= 0);
    chk(t_sref - c1 == PWR_C, "R3", "count restarted by glitch", t_sref - c1, PWR_C);
    wait (acc_cnt == N_TRIM + 2);
    hold_resp = 1'b1;
    @(negedge clk); @(negedge clk);
    zone = 2'd3; exp_q.delete(); push_all(2'd3);
    start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0; clear_meas(); acc_cnt = 0; hold_resp = 1'b0;
    chk({sysref_en, adc_reset, wr_req, spi_hold} == 4'b0001, "R11", "abort state",
        longint'({sysref_en, adc_reset, wr_req, spi_hold}), 1);
    finish_run("run B");
    chk(t_sref - c0 - 1 == PWR_C, "R11", "rerun supply wait", t_sref - c0 - 1, PWR_C);
    chk(t_rf - t_rr == RST_C, "R11", "rerun reset width", t_rf - t_rr, RST_C);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) if (cyc == 190000) begin
    n_run++; n_fail++;
    $display("FAIL R10 watchdog: actual %0d cycles expected completion earlier", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule